// File: doc/BRIEF.md
# Trace Capture Buffer Controller

This block records a stream of trace words into an on-chip store of `DEPTH` entries, then lets the same words be read back one at a time once recording has ended. A formatter upstream presents one word per cycle with a valid strobe. Control inputs arm the recorder, stop it, or force an immediate end of recording.

Two retention policies are chosen at arm time. In halt-on-full mode the first `DEPTH` words after arming are kept, and recording ends by itself. In ring mode recording never ends by itself: each new word overwrites the oldest one, so the last `DEPTH` words survive.

Readout always begins at the oldest retained entry and walks forward, wrapping modulo `DEPTH`. The block also reports three status flags (stopped, full, wrapped) and a fill count that saturates at `DEPTH`.

The controller is built around a two-state machine:
- `ST_HOLD` is the state for stopped, idle or reading out.
- `ST_RECORD` is the state for capturing.

It has three named transitions:
- `T_ARM` goes from `ST_HOLD` to `ST_RECORD` on an arm request when neither stop nor end-all is asserted.
- `T_HALT_CMD` goes from `ST_RECORD` to `ST_HOLD` on stop or end-all.
- `T_AUTO_FULL` goes from `ST_RECORD` to `ST_HOLD` in halt-on-full mode, when the word that fills the last free entry is accepted.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset, `stopped_o`=1, `full_o`=0, `wrapped_o`=0, `fill_o`=0 and `rd_valid_o`=0.
- R2: An arm request while stopped, without stop or end-all in the same cycle, clears the write position, fill count, full flag and wrapped flag, and starts recording from the next cycle.
- R3: In halt-on-full mode (`mode_ring_i`=0 at arm), the word that brings the fill count to `DEPTH` is stored and `stopped_o` rises on the same edge, with `full_o`=1. The retained words are the first `DEPTH` accepted.
- R4: In ring mode (`mode_ring_i`=1 at arm), a word accepted while the fill count is `DEPTH` overwrites the oldest entry and sets the sticky `wrapped_o`. After stopping, the store holds the last `DEPTH` accepted words.
- R5: `stop_i` during recording ends it at that edge; a word presented in the same cycle is not stored.
- R6: `end_all_i` ends recording at that edge in either mode, drops a word presented in the same cycle, and overrides an arm request in the same cycle.
- R7: While stopped, valid words are ignored: neither the fill count nor the stored contents change.
- R8: `fill_o` counts accepted words since arming, saturating at `DEPTH`; `full_o` is 1 exactly when `fill_o` equals `DEPTH`.
- R9: While stopped, each `rd_req_i` cycle returns one entry on `rd_data_o` with `rd_valid_o`=1 one cycle later. The first read returns the oldest entry: index 0 when `wrapped_o`=0, otherwise the entry at the write position. Successive reads advance modulo `DEPTH`.
- R10: `rd_req_i` during recording is ignored: `rd_valid_o` stays 0.
- R11: The retention mode is sampled at arm; changing `mode_ring_i` during recording has no effect on that recording.
- R12: A recording stopped before the store fills reports `fill_o` equal to the number of accepted words, and its readout starts at the first accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ring_i | input | 1 | Retention policy at arm: 0 halt-on-full, 1 ring |
| arm_i | input | 1 | Start a new recording (acts only while stopped) |
| stop_i | input | 1 | End the recording |
| end_all_i | input | 1 | Forced end of all recording, wins over arm |
| wr_valid_i | input | 1 | Trace word valid |
| wr_data_i | input | WIDTH | Trace word |
| rd_req_i | input | 1 | Readout request (acts only while stopped) |
| rd_data_o | output | WIDTH | Readout word |
| rd_valid_o | output | 1 | Readout word valid, one cycle after request |
| stopped_o | output | 1 | Not recording |
| full_o | output | 1 | Fill count equals DEPTH |
| wrapped_o | output | 1 | Ring mode has overwritten at least one entry |
| fill_o | output | $clog2(DEPTH+1) | Valid entries, saturating at DEPTH |

## Verification
The assertions take for granted that every control input is synchronous to `clk` and held for whole cycles. They also assume that reset is released only after the inputs are low.

The stimulus drives every input one time unit after a rising edge and samples outputs just before the next one, so no input changes near an edge.

The sweeps cover each length of accepted stream from zero to several times `DEPTH`, in both modes. Stop, end-all, readout and arm requests are issued only as whole-cycle pulses. Arm and end-all are raised together on purpose, to probe the priority between them.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
    typedef enum logic {
        ST_HOLD   = 1'b0,
        ST_RECORD = 1'b1
    } tcb_state_e;

    typedef enum logic {
        KEEP_FIRST = 1'b0,
        KEEP_LAST  = 1'b1
    } tcb_mode_e;
endpackage

// File: rtl/tcb_fsm.sv
module tcb_fsm
    import tcb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_ring_i,
    input  logic arm_i,
    input  logic stop_i,
    input  logic end_all_i,
    input  logic wr_valid_i,
    input  logic rd_req_i,
    input  logic last_slot_i,
    output logic stopped_o,
    output logic clear_o,
    output logic push_o,
    output logic rd_step_o
);
    tcb_state_e state_q, state_d;
    tcb_mode_e  mode_q, mode_d;
    logic       halt_req;

    assign halt_req = stop_i | end_all_i;

    // Next state and latched mode
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        unique case (state_q)
            ST_HOLD: begin
                if (arm_i && !halt_req) begin            // T_ARM
                    state_d = ST_RECORD;
                    mode_d  = mode_ring_i ? KEEP_LAST : KEEP_FIRST;
                end
            end
            ST_RECORD: begin
                if (halt_req) begin                      // T_HALT_CMD
                    state_d = ST_HOLD;
                end else if (wr_valid_i && last_slot_i && mode_q == KEEP_FIRST) begin
                    state_d = ST_HOLD;                   // T_AUTO_FULL
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            mode_q  <= KEEP_FIRST;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    // Outputs
    always_comb begin
        stopped_o = 1'b1;
        clear_o   = 1'b0;
        push_o    = 1'b0;
        rd_step_o = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                stopped_o = 1'b1;
                clear_o   = arm_i && !halt_req;
                rd_step_o = rd_req_i;
            end
            ST_RECORD: begin
                stopped_o = 1'b0;
                push_o    = wr_valid_i && !halt_req;
            end
            default: stopped_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/tcb_wr_track.sv
module tcb_wr_track #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             push_i,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [CNT_W-1:0] fill_o,
    output logic             full_o,
    output logic             wrapped_o,
    output logic             last_slot_o,
    output logic [PTR_W-1:0] oldest_o
);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [CNT_W-1:0] fill_q;
    logic             wrap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            fill_q <= '0;
            wrap_q <= 1'b0;
        end else if (clear_i) begin
            ptr_q  <= '0;
            fill_q <= '0;
            wrap_q <= 1'b0;
        end else if (push_i) begin
            ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
            if (fill_q == CNT_MAX) begin
                wrap_q <= 1'b1;
            end else begin
                fill_q <= fill_q + CNT_W'(1);
            end
        end
    end

    assign wr_ptr_o    = ptr_q;
    assign fill_o      = fill_q;
    assign full_o      = (fill_q == CNT_MAX);
    assign wrapped_o   = wrap_q;
    assign last_slot_o = (fill_q == CNT_LAST);
    assign oldest_o    = wrap_q ? ptr_q : '0;
endmodule

// File: rtl/tcb_rd_seq.sv
module tcb_rd_seq #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             step_i,
    input  logic [PTR_W-1:0] base_i,
    output logic [PTR_W-1:0] addr_o
);
    localparam logic [PTR_W-1:0] OFF_LAST = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W:0]   SUM_WRAP = (PTR_W + 1)'(DEPTH);

    logic [PTR_W-1:0] off_q;
    logic [PTR_W:0]   sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (restart_i) begin
            off_q <= '0;
        end else if (step_i) begin
            off_q <= (off_q == OFF_LAST) ? '0 : off_q + PTR_W'(1);
        end
    end

    always_comb begin
        sum = {1'b0, base_i} + {1'b0, off_q};
        if (sum >= SUM_WRAP) begin
            sum = sum - SUM_WRAP;
        end
        addr_o = sum[PTR_W-1:0];
    end
endmodule

// File: rtl/tcb_store.sv
module tcb_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [PTR_W-1:0] waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             re_i,
    input  logic [PTR_W-1:0] raddr_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             rvalid_o
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= re_i;
            if (re_i) begin
                rdata_o <= mem[raddr_i];
            end
        end
    end
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ring_i,
    input  logic             arm_i,
    input  logic             stop_i,
    input  logic             end_all_i,
    input  logic             wr_valid_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_req_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic             rd_valid_o,
    output logic             stopped_o,
    output logic             full_o,
    output logic             wrapped_o,
    output logic [CNT_W-1:0] fill_o
);
    logic             clear, push, rd_step, last_slot;
    logic [PTR_W-1:0] wr_ptr, oldest, rd_addr;

    tcb_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_ring_i (mode_ring_i),
        .arm_i       (arm_i),
        .stop_i      (stop_i),
        .end_all_i   (end_all_i),
        .wr_valid_i  (wr_valid_i),
        .rd_req_i    (rd_req_i),
        .last_slot_i (last_slot),
        .stopped_o   (stopped_o),
        .clear_o     (clear),
        .push_o      (push),
        .rd_step_o   (rd_step)
    );

    tcb_wr_track #(.DEPTH(DEPTH)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear),
        .push_i      (push),
        .wr_ptr_o    (wr_ptr),
        .fill_o      (fill_o),
        .full_o      (full_o),
        .wrapped_o   (wrapped_o),
        .last_slot_o (last_slot),
        .oldest_o    (oldest)
    );

    tcb_rd_seq #(.DEPTH(DEPTH)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (!stopped_o),
        .step_i    (rd_step),
        .base_i    (oldest),
        .addr_o    (rd_addr)
    );

    tcb_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (push),
        .waddr_i  (wr_ptr),
        .wdata_i  (wr_data_i),
        .re_i     (rd_step),
        .raddr_i  (rd_addr),
        .rdata_o  (rd_data_o),
        .rvalid_o (rd_valid_o)
    );
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm_i,
    input logic             stop_i,
    input logic             end_all_i,
    input logic             rd_req_i,
    input logic             rd_valid_o,
    input logic             stopped_o,
    input logic             full_o,
    input logic             wrapped_o,
    input logic [CNT_W-1:0] fill_o
);
    AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o <= CNT_W'(DEPTH)); // R8

    AST_WRAP_IMPLIES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped_o |-> full_o); // R4

    AST_END_ALL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        end_all_i |=> stopped_o); // R6

    AST_STOP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> stopped_o); // R5

    AST_READ_ONLY_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> ($past(rd_req_i) && $past(stopped_o))); // R9

    AST_IDLE_FILL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped_o && !arm_i) |=> $stable(fill_o)); // R7

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped_o && arm_i && !stop_i && !end_all_i) |=>
        (!stopped_o && fill_o == '0 && !full_o && !wrapped_o)); // R2
endmodule

bind trace_capture_buf tcb_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tcb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm_i),
    .stop_i     (stop_i),
    .end_all_i  (end_all_i),
    .rd_req_i   (rd_req_i),
    .rd_valid_o (rd_valid_o),
    .stopped_o  (stopped_o),
    .full_o     (full_o),
    .wrapped_o  (wrapped_o),
    .fill_o     (fill_o)
);

// File: tb/trace_capture_buf_tb_top.sv
`timescale 1ns/1ps
module trace_capture_buf_tb_top;
    localparam int D = 8;
    localparam int W = 16;
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_ring = 1'b0, arm = 1'b0, stop = 1'b0, end_all = 1'b0;
    logic          wr_valid = 1'b0, rd_req = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_data;
    logic          rd_valid, stopped, full, wrapped;
    logic [CW-1:0] fill;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trace_capture_buf #(.DEPTH(D), .WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_ring_i(mode_ring), .arm_i(arm),
        .stop_i(stop), .end_all_i(end_all), .wr_valid_i(wr_valid),
        .wr_data_i(wr_data), .rd_req_i(rd_req), .rd_data_o(rd_data),
        .rd_valid_o(rd_valid), .stopped_o(stopped), .full_o(full),
        .wrapped_o(wrapped), .fill_o(fill)
    );

    function automatic logic [W-1:0] word_of(int base, int i);
        return W'(base * 131 + i * 7 + 3);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_arm(input bit ring);
        mode_ring = ring;
        arm = 1'b1;
        tick();
        arm = 1'b0;
    endtask

    task automatic push(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1;
            wr_data  = word_of(base, i);
            tick();
        end
        wr_valid = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1;
        tick();
        stop = 1'b0;
    endtask

    task automatic rd_one(output logic [W-1:0] d, output logic v);
        rd_req = 1'b1;
        tick();
        d = rd_data;
        v = rd_valid;
        rd_req = 1'b0;
    endtask

    // reads cnt entries and compares with words base, first+0 .. first+cnt-1
    task automatic read_expect(input string req, input int cnt, input int base, input int first);
        logic [W-1:0] d;
        logic         v;
        for (int i = 0; i < cnt; i++) begin
            rd_one(d, v);
            chk({req, " rd_valid"}, int'(v), 1);
            chk({req, " rd_data"}, int'(d), int'(word_of(base, first + i)));
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d;
        logic         v;
        int           keep;
        int           base;

        repeat (3) tick();
        // R1 reset state
        chk("R1 stopped", int'(stopped), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 wrapped", int'(wrapped), 0);
        chk("R1 fill", int'(fill), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        tick();

        // R3 R8 R12 halt-on-full sweep
        for (int n = 0; n <= 2 * D; n++) begin
            base = 100 + n;
            keep = (n < D) ? n : D;
            do_arm(1'b0);
            chk("R2 recording after arm", int'(stopped), 0);
            chk("R2 fill cleared", int'(fill), 0);
            push(n, base);
            chk("R3 auto stop when full", int'(stopped), (n >= D) ? 1 : 0);
            if (n < D) do_stop();
            chk("R8 fill", int'(fill), keep);
            chk("R8 full", int'(full), (n >= D) ? 1 : 0);
            chk("R3 no wrap", int'(wrapped), 0);
            read_expect((n < D) ? "R12 partial readout" : "R3 first words", keep, base, 0);
            if (n >= D) read_expect("R9 wrap to oldest", 1, base, 0);
        end

        // R4 ring sweep
        for (int n = 0; n <= 3 * D; n++) begin
            base = 700 + n;
            keep = (n < D) ? n : D;
            do_arm(1'b1);
            push(n, base);
            chk("R4 still recording", int'(stopped), 0);
            do_stop();
            chk("R5 stopped", int'(stopped), 1);
            chk("R8 fill", int'(fill), keep);
            chk("R4 wrapped", int'(wrapped), (n > D) ? 1 : 0);
            read_expect("R4 last words", keep, base, (n > D) ? n - D : 0);
            if (n >= D) read_expect("R9 wrap to oldest", 1, base, (n > D) ? n - D : 0);
        end

        // R5 stop drops word in same cycle
        do_arm(1'b1);
        push(3, 40);
        wr_valid = 1'b1; wr_data = 16'hBEEF; stop = 1'b1;
        tick();
        wr_valid = 1'b0; stop = 1'b0;
        chk("R5 stopped", int'(stopped), 1);
        chk("R5 word dropped", int'(fill), 3);
        read_expect("R5 contents", 3, 40, 0);

        // R6 end-all drops word, wins over arm
        do_arm(1'b0);
        push(5, 50);
        wr_valid = 1'b1; wr_data = 16'hDEAD; end_all = 1'b1;
        tick();
        wr_valid = 1'b0; end_all = 1'b0;
        chk("R6 stopped", int'(stopped), 1);
        chk("R6 word dropped", int'(fill), 5);
        end_all = 1'b1; arm = 1'b1;
        tick();
        end_all = 1'b0; arm = 1'b0;
        chk("R6 arm overridden", int'(stopped), 1);
        chk("R6 fill kept", int'(fill), 5);

        // R7 words while stopped ignored
        push(4, 999);
        chk("R7 fill unchanged", int'(fill), 5);
        read_expect("R7 contents unchanged", 5, 50, 0);

        // R10 read during recording ignored
        do_arm(1'b1);
        push(2, 60);
        rd_req = 1'b1;
        tick();
        chk("R10 no rd_valid", int'(rd_valid), 0);
        tick();
        chk("R10 no rd_valid", int'(rd_valid), 0);
        rd_req = 1'b0;
        do_stop();
        rd_one(d, v);
        chk("R9 first entry valid", int'(v), 1);
        chk("R9 first entry", int'(d), int'(word_of(60, 0)));
        tick();
        chk("R9 valid drops", int'(rd_valid), 0);

        // R11 mode latched at arm
        do_arm(1'b0);
        mode_ring = 1'b1;
        push(2 * D, 80);
        chk("R11 halted", int'(stopped), 1);
        chk("R11 no wrap", int'(wrapped), 0);
        chk("R11 fill", int'(fill), D);
        read_expect("R11 first words", D, 80, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule